// File: doc/BRIEF.md
# Overlapping 1-0-1 Sequence Detector

This block watches a serial bit stream, taking one bit on each rising clock edge. It raises a match flag in the same cycle that the current input bit completes the pattern one, zero, one. A match can overlap the next one: the final one of a completed pattern can be the first one of the following pattern. For example, the stream 1,0,1,0,1 produces two matches.

The detector is a two-bit Mealy machine. Each state bit is held in a JK-style storage element, and a small control module works out the set and clear strobes for each element from minimized product terms. The match flag is a single combinational product of both state bits and the live input. Because of this, the flag can follow the input within a cycle, and it should be registered by the consumer if a clean, glitch-free signal is needed.

A synchronous active-high reset returns the machine to its idle state. It discards any partial pattern that has been seen.

Top module: `det101_top`

## Requirements
- R1: When `rst` is high at a rising edge, the state returns to idle. In the cycle after reset is released, `matchOut` is 0 even when `serialIn` is 1. Bits taken before the reset never contribute to a later match.
- R2: `matchOut` is 1 in a cycle if and only if both of these hold: `serialIn` is 1, and at least two bits have been taken since reset, the older of the last two being 1 and the newer being 0.
- R3: Matches overlap. The stream 1,0,1,0,1 gives `matchOut` high on its third and fifth bits and low on the others.
- R4: `matchOut` is combinational in `serialIn`. In a cycle that follows the bits 1,0, driving `serialIn` to 0 gives `matchOut` 0 and driving it to 1 gives `matchOut` 1 before the next clock edge.
- R5: Two zeros in a row clear any partial match. The stream 1,0,0,1 gives no match, and 1,0,0,1,0,1 gives exactly one match, on its last bit.
- R6: A run of ones keeps the machine armed on its last one. The stream 1,1,1,1,1,0,1 gives exactly one match, on its last bit.
- R7: `matchOut` is never high in two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is taken on each rising edge |
| rst | input | 1 | Synchronous reset, active high; forces the idle state |
| serialIn | input | 1 | Serial data bit under test |
| matchOut | output | 1 | High while the current bit completes 1,0,1 |

## Verification
A corrupted state bit shows up at the ports within at most two input bits. If the machine wrongly holds "1 then 0 seen", `matchOut` rises as soon as a 1 arrives. If it loses that state, the match it owes is missing on the very next 1. Mistakes in the set or clear terms therefore show up as a missing, extra or doubled match flag. Comparing every cycle of every eight-bit stream against a two-bit history reference, plus a long random stream, exposes every such corruption within a few cycles of when it happens.

// File: rtl/det101_pkg.sv
package det101_pkg;

  // Number of state bits held by the detector.
  localparam int STATE_W = 2;

  // Strobes from control to the storage elements, one per state bit.
  typedef struct packed {
    logic [STATE_W-1:0] jSet;
    logic [STATE_W-1:0] kClr;
  } jkStrobe_t;

  // Encodings of the reachable states.
  localparam logic [STATE_W-1:0] ST_IDLE = 2'b00;
  localparam logic [STATE_W-1:0] ST_ONE  = 2'b01;
  localparam logic [STATE_W-1:0] ST_ONEZ = 2'b11;

endpackage

// File: rtl/det101_jk_ff.sv
module det101_jk_ff (
  input  logic clk,
  input  logic rst,
  input  logic jIn,
  input  logic kIn,
  output logic qOut
);

  // Set, clear, toggle or hold; a synchronous reset wins over all of them.
  always_ff @(posedge clk) begin
    if (rst) begin
      qOut <= 1'b0;
    end else begin
      unique case ({jIn, kIn})
        2'b00:   qOut <= qOut;
        2'b01:   qOut <= 1'b0;
        2'b10:   qOut <= 1'b1;
        default: qOut <= ~qOut;
      endcase
    end
  end

endmodule

// File: rtl/det101_state_reg.sv
module det101_state_reg
  import det101_pkg::*;
#(
  parameter int W = STATE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  jkStrobe_t    strobe,
  output logic [W-1:0] stateQ
);

  // One storage element per state bit.
  for (genvar b = 0; b < W; b++) begin : g_bit
    det101_jk_ff i_ff (
      .clk  (clk),
      .rst  (rst),
      .jIn  (strobe.jSet[b]),
      .kIn  (strobe.kClr[b]),
      .qOut (stateQ[b])
    );
  end

endmodule

// File: rtl/det101_ctrl.sv
module det101_ctrl
  import det101_pkg::*;
(
  input  logic [STATE_W-1:0] stateQ,
  input  logic               serialIn,
  output jkStrobe_t          strobe,
  output logic               matchOut
);

  logic q1;
  logic q0;

  assign q1 = stateQ[1];
  assign q0 = stateQ[0];

  always_comb begin
    // Upper bit: set after "1 then 0", always cleared otherwise.
    strobe.jSet[1] = q0 & ~serialIn;
    strobe.kClr[1] = 1'b1;
    // Lower bit: set by any 1, cleared by a 0 once "1 0" was already seen.
    strobe.jSet[0] = serialIn;
    strobe.kClr[0] = q1 & ~serialIn;
  end

  // Mealy output: armed state and a live 1.
  assign matchOut = q1 & q0 & serialIn;

endmodule

// File: rtl/det101_top.sv
module det101_top
  import det101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic matchOut
);

  jkStrobe_t          strobe;
  logic [STATE_W-1:0] stateQ;

  det101_ctrl i_ctrl (
    .stateQ   (stateQ),
    .serialIn (serialIn),
    .strobe   (strobe),
    .matchOut (matchOut)
  );

  det101_state_reg #(.W(STATE_W)) i_state (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .stateQ (stateQ)
  );

endmodule

// File: rtl/det101_chk.sv
module det101_chk (
  input logic       clk,
  input logic       rst,
  input logic       serialIn,
  input logic       matchOut,
  input logic [1:0] stateQ
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (stateQ == 2'b00));

  // R2
  match_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> !$past(serialIn));

  // R2
  no_dead_state_chk: assert property (@(posedge clk) disable iff (rst)
    stateQ != 2'b10);

  // R3
  overlap_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> (stateQ == 2'b01));

  // R4
  match_live_chk: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> serialIn);

  // R5
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'b11 && !serialIn) |=> (stateQ == 2'b00));

  // R7
  no_double_chk: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> !matchOut);

endmodule

bind det101_top det101_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .matchOut (matchOut),
  .stateQ   (stateQ)
);

// File: tb/test_det101_top.sv
module test_det101_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic matchOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference: last two bits taken and how many were taken since reset.
  logic [1:0] hist = 2'b00;
  int seen = 0;
  int matchCount = 0;
  logic prevMatch = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  det101_top i_det101_top (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .matchOut (matchOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hist = 2'b00;
    seen = 0;
    matchCount = 0;
    prevMatch = 1'b0;
  endtask

  // Drive one bit after a falling edge, compare before the rising edge.
  task automatic applyBit(input logic b, input string tag);
    logic exp;
    if (rst) @(negedge clk);
    serialIn = b;
    #(CLK_PERIOD/4);
    exp = b && (seen >= 2) && (hist == 2'b10);
    check(tag, matchOut, exp);
    if (prevMatch && matchOut) check("R7", 1'b1, 1'b0);
    if (matchOut === 1'b1) matchCount++;
    prevMatch = matchOut;
    hist = {hist[0], b};
    seen++;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: the first bit after reset is a 1 and must not match
    doReset();
    applyBit(1'b1, "R1");
    // R1: a partial "1 0" before reset is forgotten
    doReset();
    applyBit(1'b1, "R1");
    applyBit(1'b0, "R1");
    doReset();
    applyBit(1'b1, "R1");
    checkInt("R1", matchCount, 0);

    // R3: overlapping matches on 1,0,1,0,1
    doReset();
    applyBit(1'b1, "R3");
    applyBit(1'b0, "R3");
    applyBit(1'b1, "R3");
    applyBit(1'b0, "R3");
    applyBit(1'b1, "R3");
    checkInt("R3", matchCount, 2);

    // R4: output follows the live input inside one cycle
    doReset();
    applyBit(1'b1, "R4");
    applyBit(1'b0, "R4");
    serialIn = 1'b0;
    #(CLK_PERIOD/8);
    check("R4", matchOut, 1'b0);
    serialIn = 1'b1;
    #(CLK_PERIOD/8);
    check("R4", matchOut, 1'b1);
    serialIn = 1'b0;
    #(CLK_PERIOD/8);
    check("R4", matchOut, 1'b0);

    // R5: two zeros clear a partial match
    doReset();
    applyBit(1'b1, "R5");
    applyBit(1'b0, "R5");
    applyBit(1'b0, "R5");
    applyBit(1'b1, "R5");
    checkInt("R5", matchCount, 0);
    applyBit(1'b0, "R5");
    applyBit(1'b1, "R5");
    checkInt("R5", matchCount, 1);

    // R6: a run of ones then 0,1
    doReset();
    for (int i = 0; i < 5; i++) applyBit(1'b1, "R6");
    applyBit(1'b0, "R6");
    applyBit(1'b1, "R6");
    checkInt("R6", matchCount, 1);

    // R2: every eight-bit stream from reset
    for (int n = 0; n < 256; n++) begin
      doReset();
      for (int k = 7; k >= 0; k--) applyBit(n[k], "R2");
    end

    // R2 and R7: long pseudo-random stream
    doReset();
    for (int i = 0; i < 3000; i++) applyBit(1'($urandom_range(1, 0)), "R2");

    finishRun();
  end

endmodule